// File: doc/BRIEF.md
# Privilege-checked interrupt list register file

This block keeps a small bank of virtual interrupt list entries. A hypervisor fills them to hand interrupt context to a virtual CPU interface. Software reaches the bank through a coprocessor-style access port. Each access carries a read/write flag, the coprocessor number, two opcode fields, two register fields, the current privilege level, and a few control bits: hypervisor implemented, hypervisor enabled, hypervisor 64-bit mode, a level-1 trap enable, and register-interface enables for levels 2 and 3.

For every valid access the block first checks whether the encoding targets the bank. It then builds an entry index from one register field bit and the second opcode field. A privilege cascade then resolves the access to exactly one result: it completes, it raises an undefined-instruction fault, or it traps to the hypervisor. A trap also reports the hypervisor mode and a fixed syndrome code.

Reads return the masked entry combinationally in the same cycle. A completed write lands on the next clock edge. The number of entries and the implemented interrupt-ID width are parameters, and both are reported on constant outputs.

Top module: `vlr_bank`

## Requirements
- R1: An access targets the bank only when the coprocessor field is 15, opc1 is 4, CRn is 12 and CRm[3:1] is 6. Any other encoding gives no completion, no fault, no trap and zero read data, and it leaves every entry unchanged.
- R2: The entry index is {CRm[0], opc2[2:0]}, which covers 0 to 15. A completed read returns the entry at that index, zero-extended to 32 bits.
- R3: A bank access from privilege level 0 always raises the undefined-instruction fault.
- R4: At level 1, when the hypervisor is implemented, enabled and the trap enable is set, the access traps. The trap output is 1, the syndrome code output is 0x03, and the mode output equals the hypervisor 64-bit input. Every other level-1 access raises the fault.
- R5: At level 2 the access completes only when the hypervisor is implemented and the level-2 interface enable is 1. Otherwise it faults.
- R6: At level 3 with the hypervisor implemented, the access completes only when the level-3 interface enable is 1. Otherwise it faults.
- R7: At level 3 with no hypervisor implemented, the access completes at any index. It reads as zero, and a write changes no entry.
- R8: On the level-2 and level-3 completion paths, an index at or above the number of entries (parameter NUM_LR, 1 to 16) raises the fault.
- R9: Only the low ID_BITS (16 to 32) of an entry are stored. Higher bits read as zero and writes to them are dropped.
- R10: After reset every entry reads as zero.
- R11: A completed write is readable in the next cycle. Read data appears in the cycle the access is presented and is zero for writes, faults, traps and idle cycles. A faulting or trapped access modifies nothing. At most one of completion, fault and trap is asserted in a cycle.
- R12: cfg_entries reports NUM_LR and cfg_id_bits reports ID_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_coproc | input | 4 | Coprocessor number |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_level | input | 2 | Current privilege level 0 to 3 |
| acc_wdata | input | 32 | Write data |
| hyp_impl | input | 1 | Hypervisor level implemented |
| hyp_enabled | input | 1 | Hypervisor enabled for the current context |
| hyp_is_a64 | input | 1 | Hypervisor runs in 64-bit mode |
| trap_en | input | 1 | Level-1 trap enable |
| sre_l2 | input | 1 | Level-2 register-interface enable |
| sre_l3 | input | 1 | Level-3 register-interface enable |
| rsp_done | output | 1 | Access completed this cycle |
| rsp_undef | output | 1 | Undefined-instruction fault |
| rsp_trap | output | 1 | Trap to hypervisor |
| rsp_trap_a64 | output | 1 | Trap targets the 64-bit hypervisor |
| rsp_trap_code | output | 6 | Trap syndrome code, 0x03 on trap, else 0 |
| rsp_rdata | output | 32 | Read data |
| cfg_entries | output | 5 | Number of implemented entries |
| cfg_id_bits | output | 6 | Implemented interrupt-ID width |

## Verification
A write can commit on a clock edge while the next access, in the following cycle, reads the same entry or is refused. The bench issues every write and its read-back on consecutive cycles with no idle cycle between them, so the read must show the value committed at that edge.

The bench also puts faulting and trapped writes directly before matching reads. This checks that a refused access in one cycle leaves the entry intact for its neighbour. Expected results come from a bench model that tracks only completed, masked, non-read-as-zero writes.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int LR_MAX = 16;
    localparam int IDX_W  = 4;

    localparam logic [3:0] CP_NUM   = 4'd15;
    localparam logic [2:0] OPC1_VAL = 3'd4;
    localparam logic [3:0] CRN_VAL  = 4'd12;
    localparam logic [2:0] CRM_HI   = 3'd6;

    localparam logic [5:0] TRAP_CODE = 6'h03;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_DONE,
        ACC_UNDEF,
        ACC_TRAP
    } acc_res_e;

    typedef struct packed {
        acc_res_e res;
        logic     a64;
        logic     raz;
    } perm_t;

endpackage

// File: rtl/vlr_decode.sv
module vlr_decode
    import vlr_pkg::*;
(
    input  logic [3:0]       coproc,
    input  logic [2:0]       opc1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       opc2,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit = (coproc == CP_NUM) && (opc1 == OPC1_VAL) &&
              (crn == CRN_VAL) && (crm[3:1] == CRM_HI);
        idx = {crm[0], opc2};
    end

endmodule

// File: rtl/vlr_perm.sv
module vlr_perm
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 12
) (
    input  logic             valid,
    input  logic             hit,
    input  logic [1:0]       level,
    input  logic [IDX_W-1:0] idx,
    input  logic             hyp_impl,
    input  logic             hyp_en,
    input  logic             hyp_a64,
    input  logic             trap_en,
    input  logic             sre_l2,
    input  logic             sre_l3,
    output perm_t            perm
);

    localparam int CNT_W = IDX_W + 1;

    logic in_range;

    always_comb begin
        in_range = {1'b0, idx} < CNT_W'(NUM_LR);
        perm.res = ACC_NONE;
        perm.a64 = 1'b0;
        perm.raz = 1'b0;
        if (valid && hit) begin
            unique case (level)
                2'd0: perm.res = ACC_UNDEF;
                2'd1: begin
                    if (hyp_impl && hyp_en && trap_en) begin
                        perm.res = ACC_TRAP;
                        perm.a64 = hyp_a64;
                    end else begin
                        perm.res = ACC_UNDEF;
                    end
                end
                2'd2: perm.res = (hyp_impl && sre_l2 && in_range) ? ACC_DONE : ACC_UNDEF;
                default: begin
                    if (!hyp_impl) begin
                        perm.res = ACC_DONE;
                        perm.raz = 1'b1;
                    end else begin
                        perm.res = (sre_l3 && in_range) ? ACC_DONE : ACC_UNDEF;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vlr_store.sv
module vlr_store
    import vlr_pkg::*;
#(
    parameter int NUM_LR  = 12,
    parameter int ID_BITS = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [ID_BITS-1:0]        wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [ID_BITS-1:0]        rd_data,
    output logic [NUM_LR*ID_BITS-1:0] ent_view
);

    typedef struct packed {
        logic [NUM_LR-1:0][ID_BITS-1:0] ent;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        rd_data = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                s_d.ent[i] = wr_data;
            end
            if (rd_idx == IDX_W'(i)) begin
                rd_data = s_q.ent[i];
            end
        end
        ent_view = s_q.ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/vlr_bank.sv
module vlr_bank
    import vlr_pkg::*;
#(
    parameter int NUM_LR  = 12,
    parameter int ID_BITS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [3:0]  acc_coproc,
    input  logic [2:0]  acc_opc1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_opc2,
    input  logic [1:0]  acc_level,
    input  logic [31:0] acc_wdata,
    input  logic        hyp_impl,
    input  logic        hyp_enabled,
    input  logic        hyp_is_a64,
    input  logic        trap_en,
    input  logic        sre_l2,
    input  logic        sre_l3,
    output logic        rsp_done,
    output logic        rsp_undef,
    output logic        rsp_trap,
    output logic        rsp_trap_a64,
    output logic [5:0]  rsp_trap_code,
    output logic [31:0] rsp_rdata,
    output logic [4:0]  cfg_entries,
    output logic [5:0]  cfg_id_bits
);

    logic                      hit;
    logic [IDX_W-1:0]          idx;
    perm_t                     perm;
    logic                      wr_fire;
    logic                      lr_raz;
    logic [ID_BITS-1:0]        rd_entry;
    logic [NUM_LR*ID_BITS-1:0] ent_view;

    vlr_decode u_dec (
        .coproc (acc_coproc),
        .opc1   (acc_opc1),
        .crn    (acc_crn),
        .crm    (acc_crm),
        .opc2   (acc_opc2),
        .hit    (hit),
        .idx    (idx)
    );

    vlr_perm #(.NUM_LR(NUM_LR)) u_perm (
        .valid    (acc_valid),
        .hit      (hit),
        .level    (acc_level),
        .idx      (idx),
        .hyp_impl (hyp_impl),
        .hyp_en   (hyp_enabled),
        .hyp_a64  (hyp_is_a64),
        .trap_en  (trap_en),
        .sre_l2   (sre_l2),
        .sre_l3   (sre_l3),
        .perm     (perm)
    );

    vlr_store #(.NUM_LR(NUM_LR), .ID_BITS(ID_BITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fire),
        .wr_idx   (idx),
        .wr_data  (acc_wdata[ID_BITS-1:0]),
        .rd_idx   (idx),
        .rd_data  (rd_entry),
        .ent_view (ent_view)
    );

    generate
        if (ID_BITS < 32) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^acc_wdata[31:ID_BITS];
        end
    endgenerate

    always_comb begin
        rsp_done      = (perm.res == ACC_DONE);
        rsp_undef     = (perm.res == ACC_UNDEF);
        rsp_trap      = (perm.res == ACC_TRAP);
        rsp_trap_a64  = perm.a64;
        rsp_trap_code = rsp_trap ? TRAP_CODE : 6'd0;
        lr_raz        = perm.raz;
        wr_fire       = rsp_done && acc_write && !lr_raz;
        rsp_rdata     = (rsp_done && !acc_write && !lr_raz) ? 32'(rd_entry) : 32'd0;
        cfg_entries   = 5'(NUM_LR);
        cfg_id_bits   = 6'(ID_BITS);
    end

endmodule

// File: rtl/vlr_bank_chk.sv
module vlr_bank_chk #(
    parameter int NUM_LR  = 12,
    parameter int ID_BITS = 20
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic [1:0]                acc_level,
    input logic                      sre_l2,
    input logic                      rsp_done,
    input logic                      rsp_undef,
    input logic                      rsp_trap,
    input logic [5:0]                rsp_trap_code,
    input logic [31:0]               rsp_rdata,
    input logic                      lr_raz,
    input logic [NUM_LR*ID_BITS-1:0] ent_view
);

    p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_done, rsp_undef, rsp_trap}));

    p_level0_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_level == 2'd0 && (rsp_done || rsp_trap || rsp_undef)) |-> rsp_undef);

    p_trap_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_trap_code == 6'h03 && acc_level == 2'd1));

    p_level2_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && acc_level == 2'd2) |-> sre_l2);

    p_refused_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_undef || rsp_trap || !acc_valid) |=> $stable(ent_view));

    p_raz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_raz |-> (rsp_rdata == 32'd0));

    p_raz_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_raz |=> $stable(ent_view));

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_rdata == 32'd0));

    generate
        if (ID_BITS < 32) begin : g_hi
            p_top_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_rdata[31:ID_BITS] == '0);
        end
    endgenerate

endmodule

bind vlr_bank vlr_bank_chk #(.NUM_LR(NUM_LR), .ID_BITS(ID_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_level     (acc_level),
    .sre_l2        (sre_l2),
    .rsp_done      (rsp_done),
    .rsp_undef     (rsp_undef),
    .rsp_trap      (rsp_trap),
    .rsp_trap_code (rsp_trap_code),
    .rsp_rdata     (rsp_rdata),
    .lr_raz        (lr_raz),
    .ent_view      (ent_view)
);

// File: tb/vlr_bank_test.sv
module vlr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 12;
    localparam int IDB = 20;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_coproc = '0;
    logic [2:0]  acc_opc1 = '0;
    logic [3:0]  acc_crn = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_opc2 = '0;
    logic [1:0]  acc_level = '0;
    logic [31:0] acc_wdata = '0;
    logic        hyp_impl = 1'b1;
    logic        hyp_enabled = 1'b1;
    logic        hyp_is_a64 = 1'b0;
    logic        trap_en = 1'b0;
    logic        sre_l2 = 1'b1;
    logic        sre_l3 = 1'b1;
    logic        rsp_done, rsp_undef, rsp_trap, rsp_trap_a64;
    logic [5:0]  rsp_trap_code;
    logic [31:0] rsp_rdata;
    logic [4:0]  cfg_entries;
    logic [5:0]  cfg_id_bits;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlr_bank #(.NUM_LR(N), .ID_BITS(IDB)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_level(acc_level),
        .acc_wdata(acc_wdata), .hyp_impl(hyp_impl), .hyp_enabled(hyp_enabled),
        .hyp_is_a64(hyp_is_a64), .trap_en(trap_en), .sre_l2(sre_l2), .sre_l3(sre_l3),
        .rsp_done(rsp_done), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
        .rsp_trap_a64(rsp_trap_a64), .rsp_trap_code(rsp_trap_code),
        .rsp_rdata(rsp_rdata), .cfg_entries(cfg_entries), .cfg_id_bits(cfg_id_bits)
    );

    function automatic logic [31:0] id_mask();
        return 32'((64'd1 << IDB) - 64'd1);
    endfunction

    task automatic check(input string req, input logic [41:0] act, input logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive after negedge, sample combinational results, commit at posedge.
    task automatic acc(input logic wr, input logic [3:0] cp, input logic [2:0] o1,
                       input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                       input logic [1:0] lv, input logic [31:0] wd, input string req);
        logic hit, e_done, e_undef, e_trap, e_a64, raz;
        logic [3:0] ix;
        logic [31:0] e_rd;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_coproc = cp; acc_opc1 = o1;
        acc_crn = cn; acc_crm = cm; acc_opc2 = o2; acc_level = lv; acc_wdata = wd;
        #1;
        hit = (cp == 4'd15) && (o1 == 3'd4) && (cn == 4'd12) && (cm[3:1] == 3'd6);
        ix = {cm[0], o2};
        e_done = 0; e_undef = 0; e_trap = 0; e_a64 = 0; raz = 0;
        if (hit) begin
            if (lv == 0) e_undef = 1;
            else if (lv == 1) begin
                if (hyp_impl && hyp_enabled && trap_en) begin e_trap = 1; e_a64 = hyp_is_a64; end
                else e_undef = 1;
            end else if (lv == 2) begin
                if (hyp_impl && sre_l2 && int'(ix) < N) e_done = 1; else e_undef = 1;
            end else begin
                if (!hyp_impl) begin e_done = 1; raz = 1; end
                else if (sre_l3 && int'(ix) < N) e_done = 1;
                else e_undef = 1;
            end
        end
        e_rd = (e_done && !wr && !raz) ? model[ix] : 32'd0;
        check(req, {rsp_done, rsp_undef, rsp_trap, rsp_trap_a64, rsp_trap_code, rsp_rdata},
                   {e_done, e_undef, e_trap, e_a64, (e_trap ? 6'h03 : 6'h00), e_rd});
        if (e_done && wr && !raz) model[ix] = wd & id_mask();
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic lr(input logic wr, input int ix, input logic [1:0] lv,
                      input logic [31:0] wd, input string req);
        acc(wr, 4'd15, 3'd4, 4'd12, {3'd6, 1'(ix >> 3)}, 3'(ix), lv, wd, req);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) model[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 constant configuration outputs
        checks++;
        if (cfg_entries !== 5'(N) || cfg_id_bits !== 6'(IDB)) begin
            failures++;
            $display("FAIL R12 actual=%0d/%0d expected=%0d/%0d", cfg_entries, cfg_id_bits, N, IDB);
        end

        // R10 reset contents, R8 out-of-range indices fault
        for (int i = 0; i < 16; i++) lr(1'b0, i, 2'd2, 32'd0, "R10 R8");

        // R2 R9 R11: full-width writes then back-to-back read-back
        for (int i = 0; i < 16; i++) begin
            lr(1'b1, i, 2'd2, 32'hFEDC_0000 ^ (32'(i) * 32'h1111_1111), "R2 R9 R8");
            lr(1'b0, i, 2'd2, 32'd0, "R2 R9 R11");
        end
        for (int i = 0; i < 16; i++) lr(1'b0, i, 2'd3, 32'd0, "R6 R2");

        // Permission sweep: R3 R4 R5 R6 R7 R8 R11
        for (int c = 0; c < 256; c++) begin
            logic [1:0] lv;
            int ix;
            string tg;
            lv = 2'(c);
            hyp_impl    = c[2];
            hyp_enabled = c[3];
            trap_en     = c[4];
            sre_l2      = c[5];
            sre_l3      = c[6];
            hyp_is_a64  = c[7] ^ c[0];
            ix = (c * 7) % 16;
            tg = (lv == 0) ? "R3" : (lv == 1) ? "R4" : (lv == 2) ? "R5 R8" : "R6 R7 R8";
            lr(1'b1, ix, lv, 32'h5A00_0000 ^ (32'(c) * 32'h0001_0203), tg);
            hyp_impl = 1'b1; sre_l2 = 1'b1;
            lr(1'b0, ix, 2'd2, 32'd0, "R11 R7");
        end

        // R1: encodings that miss the bank, each followed by a read-back
        hyp_impl = 1'b1; sre_l2 = 1'b1; sre_l3 = 1'b1; trap_en = 1'b0;
        acc(1'b1, 4'd14, 3'd4, 4'd12, 4'd12, 3'd1, 2'd2, 32'h1234_5678, "R1");
        lr(1'b0, 1, 2'd2, 32'd0, "R1");
        acc(1'b1, 4'd15, 3'd3, 4'd12, 4'd12, 3'd2, 2'd2, 32'h2345_6789, "R1");
        lr(1'b0, 2, 2'd2, 32'd0, "R1");
        acc(1'b1, 4'd15, 3'd4, 4'd13, 4'd12, 3'd3, 2'd2, 32'h3456_789A, "R1");
        lr(1'b0, 3, 2'd2, 32'd0, "R1");
        for (int m = 0; m < 16; m++) begin
            if (m[3:1] != 3'd6) begin
                acc(1'b1, 4'd15, 3'd4, 4'd12, 4'(m), 3'd4, 2'd2, 32'hABCD_0000 + 32'(m), "R1");
                lr(1'b0, 4, 2'd2, 32'd0, "R1");
                lr(1'b0, 12, 2'd2, 32'd0, "R1 R8");
            end
        end

        // R4: trap mode follows the hypervisor mode input
        hyp_enabled = 1'b1; trap_en = 1'b1;
        hyp_is_a64 = 1'b1; lr(1'b1, 0, 2'd1, 32'hFFFF_FFFF, "R4");
        hyp_is_a64 = 1'b0; lr(1'b0, 0, 2'd1, 32'd0, "R4");
        lr(1'b0, 0, 2'd2, 32'd0, "R4 R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule